// File: doc/BRIEF.md
# Delayed Branch and Trap Sequencer

This block works out the program-counter flow of a processor whose branches have one delay slot. The decoder hands it one instruction per retire strobe: the PC of that instruction, a branch kind, a displacement, a register operand and the current T flag. A branch kind latches a target and marks the next retiring instruction as the delay slot. That target is applied only when the delay-slot instruction itself retires, and only if the branch was taken.

The block also holds the procedure return register, the saved PC, the saved status word and the trap register. Subroutine calls write the return address. Return-from-exception hands back the saved status word. A trap or an undefined instruction raises an exception request with a code. When the faulting instruction sits in a delay slot, the code is a separate one and the pending branch is dropped.

All outputs are registered. They take their new values on the clock edge where `retire_i` is high.

Top module: `dslot_branch_unit`

## Requirements
- R1: Synchronous active-high reset sets `next_pc_o` to `RESET_PC` (default 0xA0000000) and clears `in_slot_o`, `taken_o`, `exc_req_o`, `exc_code_o`, `sr_wr_o`, `pr_o`, `tra_o` and the saved registers.
- R2: `kind_i` encodes the instruction as follows: 0 plain, 1 branch-if-T, 2 branch-if-not-T, 3 PC-relative jump, 4 register-relative jump, 5 register-indirect jump, 6 PC-relative call, 7 register-relative call, 8 register-indirect call, 9 return, 10 return-from-exception, 11 trap, 12 undefined, 13 load return register, 14 load saved status, 15 load saved PC. A retired plain instruction outside a slot gives `next_pc_o` = `pc_i` + 2 and no exception.
- R3: Kinds 1 and 2 always latch target `pc_i`+4+`disp_i`, set `next_pc_o` to `pc_i`+2 and set `in_slot_o`. `taken_o` is set only when T is 1 (kind 1) or T is 0 (kind 2).
- R4: Kinds 3 and 6 target `pc_i`+4+`disp_i`. Kinds 4 and 7 target `pc_i`+4+`opr_i`. Kinds 5 and 8 target `opr_i`. All of these are taken unconditionally.
- R5: Call kinds (6, 7, 8) write `pc_i`+4 into `pr_o`. Return (kind 9) targets the value `pr_o` held before it.
- R6: Return-from-exception (kind 10) targets the saved PC. On the next cycle it pulses `sr_wr_o` for one cycle, with `sr_val_o` equal to the saved status.
- R7: When the delay-slot instruction retires, `in_slot_o` and `taken_o` clear. `next_pc_o` becomes the latched target if the branch was taken, otherwise `pc_i`+2.
- R8: A trap (kind 11) outside a slot sets `tra_o` to `disp_i[7:0]` shifted left by 2. It pulses `exc_req_o` for one cycle with `exc_code_o` = 0x160.
- R9: An undefined instruction (kind 12) outside a slot pulses `exc_req_o` with code 0x180.
- R10: Kinds 1 to 12 retiring in a delay slot pulse `exc_req_o` with code 0x1A0. They drop the pending branch (`next_pc_o` = `pc_i`+2) and write no register.
- R11: While `retire_i` is low, `next_pc_o`, `in_slot_o`, `taken_o` and all held registers keep their values, and no exception or status write is signalled.
- R12: Kinds 13, 14 and 15 load `opr_i` into the return register, saved status and saved PC respectively. They are allowed inside a delay slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | An instruction retires this cycle |
| kind_i | input | 4 | Branch kind of the retiring instruction (see R2) |
| pc_i | input | 32 | PC of the retiring instruction |
| disp_i | input | 32 | Sign-extended scaled displacement; low 8 bits are the trap immediate |
| opr_i | input | 32 | Register operand |
| t_i | input | 1 | Current T flag |
| next_pc_o | output | 32 | PC to fetch next |
| in_slot_o | output | 1 | Next retiring instruction is a delay slot |
| taken_o | output | 1 | Pending branch will be taken |
| pr_o | output | 32 | Procedure return register |
| tra_o | output | 32 | Trap register |
| exc_req_o | output | 1 | One-cycle exception request |
| exc_code_o | output | 12 | Exception code, zero when no request |
| sr_wr_o | output | 1 | One-cycle status-word restore strobe |
| sr_val_o | output | 32 | Status word to restore |

## Verification
The hardest states to reach from the ports are the ones that exist only while a delay slot is open. Examples are a second branch, a call or an undefined instruction retiring as the slot instruction, and retire gaps that fall between a branch and its slot. The stimulus table chains instructions so that each branch is followed directly by the instruction under test. This puts slot faults, register loads inside a slot, and returns through a return register that was rewritten inside a slot into fixed positions. Directed steps then hold `retire_i` low with an undefined kind on the bus while a taken branch is pending, to show that nothing moves until the slot retires.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

    localparam int DSB_XLEN   = 32;
    localparam int DSB_CODE_W = 12;

    localparam logic [DSB_CODE_W-1:0] EXC_TRAP      = 12'h160;
    localparam logic [DSB_CODE_W-1:0] EXC_UNDEF     = 12'h180;
    localparam logic [DSB_CODE_W-1:0] EXC_SLOT_FLT  = 12'h1A0;

    typedef enum logic [3:0] {
        K_NONE  = 4'd0,
        K_BT    = 4'd1,
        K_BF    = 4'd2,
        K_BRA   = 4'd3,
        K_BRAR  = 4'd4,
        K_JMP   = 4'd5,
        K_CALL  = 4'd6,
        K_CALLR = 4'd7,
        K_JCALL = 4'd8,
        K_RET   = 4'd9,
        K_ERET  = 4'd10,
        K_TRAP  = 4'd11,
        K_UNDEF = 4'd12,
        K_LDPR  = 4'd13,
        K_LDSSR = 4'd14,
        K_LDSPC = 4'd15
    } kind_e;

    typedef struct packed {
        logic                dly;
        logic                taken;
        logic [DSB_XLEN-1:0] target;
    } redirect_t;

    function automatic logic is_delayed(kind_e k);
        return k inside {K_BT, K_BF, K_BRA, K_BRAR, K_JMP,
                         K_CALL, K_CALLR, K_JCALL, K_RET, K_ERET};
    endfunction

    function automatic logic is_call(kind_e k);
        return k inside {K_CALL, K_CALLR, K_JCALL};
    endfunction

    function automatic logic faults_in_slot(kind_e k);
        return is_delayed(k) || (k == K_TRAP) || (k == K_UNDEF);
    endfunction

endpackage

// File: rtl/dsb_target_calc.sv
module dsb_target_calc
    import dsb_pkg::*;
#(
    parameter int LINK_OFS = 4
) (
    input  kind_e                kind_i,
    input  logic [DSB_XLEN-1:0]  pc_i,
    input  logic [DSB_XLEN-1:0]  disp_i,
    input  logic [DSB_XLEN-1:0]  opr_i,
    input  logic                 t_i,
    input  logic [DSB_XLEN-1:0]  pr_i,
    input  logic [DSB_XLEN-1:0]  spc_i,
    output redirect_t            redir_o
);

    localparam logic [DSB_XLEN-1:0] LINK = DSB_XLEN'(LINK_OFS);

    logic [DSB_XLEN-1:0] pc_link;
    assign pc_link = pc_i + LINK;

    always_comb begin
        redir_o = '0;
        unique case (kind_i)
            K_BT: begin
                redir_o.dly    = 1'b1;
                redir_o.taken  = t_i;
                redir_o.target = pc_link + disp_i;
            end
            K_BF: begin
                redir_o.dly    = 1'b1;
                redir_o.taken  = ~t_i;
                redir_o.target = pc_link + disp_i;
            end
            K_BRA, K_CALL: begin
                redir_o.dly    = 1'b1;
                redir_o.taken  = 1'b1;
                redir_o.target = pc_link + disp_i;
            end
            K_BRAR, K_CALLR: begin
                redir_o.dly    = 1'b1;
                redir_o.taken  = 1'b1;
                redir_o.target = pc_link + opr_i;
            end
            K_JMP, K_JCALL: begin
                redir_o.dly    = 1'b1;
                redir_o.taken  = 1'b1;
                redir_o.target = opr_i;
            end
            K_RET: begin
                redir_o.dly    = 1'b1;
                redir_o.taken  = 1'b1;
                redir_o.target = pr_i;
            end
            K_ERET: begin
                redir_o.dly    = 1'b1;
                redir_o.taken  = 1'b1;
                redir_o.target = spc_i;
            end
            default: redir_o = '0;
        endcase
    end

endmodule

// File: rtl/dsb_save_regs.sv
module dsb_save_regs
    import dsb_pkg::*;
#(
    parameter int LINK_OFS   = 4,
    parameter int TRAP_IMM_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   accept_i,
    input  kind_e                  kind_i,
    input  logic [DSB_XLEN-1:0]    pc_i,
    input  logic [DSB_XLEN-1:0]    opr_i,
    input  logic [TRAP_IMM_W-1:0]  imm_i,
    output logic [DSB_XLEN-1:0]    pr_o,
    output logic [DSB_XLEN-1:0]    ssr_o,
    output logic [DSB_XLEN-1:0]    spc_o,
    output logic [DSB_XLEN-1:0]    tra_o
);

    localparam logic [DSB_XLEN-1:0] LINK = DSB_XLEN'(LINK_OFS);

    always_ff @(posedge clk) begin
        if (rst) begin
            pr_o  <= '0;
            ssr_o <= '0;
            spc_o <= '0;
            tra_o <= '0;
        end else if (accept_i) begin
            if (is_call(kind_i)) begin
                pr_o <= pc_i + LINK;
            end
            unique case (kind_i)
                K_LDPR:  pr_o  <= opr_i;
                K_LDSSR: ssr_o <= opr_i;
                K_LDSPC: spc_o <= opr_i;
                K_TRAP:  tra_o <= DSB_XLEN'({imm_i, 2'b00});
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dsb_slot_ctrl.sv
module dsb_slot_ctrl
    import dsb_pkg::*;
#(
    parameter int                  PC_STEP  = 2,
    parameter logic [DSB_XLEN-1:0] RESET_PC = 32'hA000_0000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   retire_i,
    input  kind_e                  kind_i,
    input  logic [DSB_XLEN-1:0]    pc_i,
    input  logic                   dly_i,
    input  logic                   taken_i,
    input  logic [DSB_XLEN-1:0]    target_i,
    input  logic [DSB_XLEN-1:0]    ssr_i,
    output logic                   accept_o,
    output logic [DSB_XLEN-1:0]    next_pc_o,
    output logic                   in_slot_o,
    output logic                   taken_o,
    output logic                   exc_req_o,
    output logic [DSB_CODE_W-1:0]  exc_code_o,
    output logic                   sr_wr_o,
    output logic [DSB_XLEN-1:0]    sr_val_o
);

    localparam logic [DSB_XLEN-1:0] STEP = DSB_XLEN'(PC_STEP);

    logic [DSB_XLEN-1:0] target_q;
    logic                slot_fault;
    logic [DSB_XLEN-1:0] seq_pc;

    assign slot_fault = in_slot_o && faults_in_slot(kind_i);
    assign accept_o   = retire_i && !slot_fault;
    assign seq_pc     = pc_i + STEP;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc_o  <= RESET_PC;
            in_slot_o  <= 1'b0;
            taken_o    <= 1'b0;
            target_q   <= '0;
            exc_req_o  <= 1'b0;
            exc_code_o <= '0;
            sr_wr_o    <= 1'b0;
            sr_val_o   <= '0;
        end else begin
            exc_req_o  <= 1'b0;
            exc_code_o <= '0;
            sr_wr_o    <= 1'b0;
            if (retire_i) begin
                if (in_slot_o) begin
                    in_slot_o <= 1'b0;
                    taken_o   <= 1'b0;
                    if (slot_fault) begin
                        exc_req_o  <= 1'b1;
                        exc_code_o <= EXC_SLOT_FLT;
                        next_pc_o  <= seq_pc;
                    end else begin
                        next_pc_o <= taken_o ? target_q : seq_pc;
                    end
                end else begin
                    next_pc_o <= seq_pc;
                    if (kind_i == K_UNDEF) begin
                        exc_req_o  <= 1'b1;
                        exc_code_o <= EXC_UNDEF;
                    end else if (kind_i == K_TRAP) begin
                        exc_req_o  <= 1'b1;
                        exc_code_o <= EXC_TRAP;
                    end else if (dly_i) begin
                        in_slot_o <= 1'b1;
                        taken_o   <= taken_i;
                        target_q  <= target_i;
                        if (kind_i == K_ERET) begin
                            sr_wr_o  <= 1'b1;
                            sr_val_o <= ssr_i;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dslot_branch_unit.sv
module dslot_branch_unit
    import dsb_pkg::*;
#(
    parameter int                  PC_STEP    = 2,
    parameter int                  LINK_OFS   = 4,
    parameter int                  TRAP_IMM_W = 8,
    parameter logic [DSB_XLEN-1:0] RESET_PC   = 32'hA000_0000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   retire_i,
    input  logic [3:0]             kind_i,
    input  logic [DSB_XLEN-1:0]    pc_i,
    input  logic [DSB_XLEN-1:0]    disp_i,
    input  logic [DSB_XLEN-1:0]    opr_i,
    input  logic                   t_i,
    output logic [DSB_XLEN-1:0]    next_pc_o,
    output logic                   in_slot_o,
    output logic                   taken_o,
    output logic [DSB_XLEN-1:0]    pr_o,
    output logic [DSB_XLEN-1:0]    tra_o,
    output logic                   exc_req_o,
    output logic [DSB_CODE_W-1:0]  exc_code_o,
    output logic                   sr_wr_o,
    output logic [DSB_XLEN-1:0]    sr_val_o
);

    kind_e               kind;
    redirect_t           redir;
    logic                accept;
    logic [DSB_XLEN-1:0] ssr;
    logic [DSB_XLEN-1:0] spc;

    assign kind = kind_e'(kind_i);

    dsb_target_calc #(
        .LINK_OFS (LINK_OFS)
    ) u_calc (
        .kind_i  (kind),
        .pc_i    (pc_i),
        .disp_i  (disp_i),
        .opr_i   (opr_i),
        .t_i     (t_i),
        .pr_i    (pr_o),
        .spc_i   (spc),
        .redir_o (redir)
    );

    dsb_save_regs #(
        .LINK_OFS   (LINK_OFS),
        .TRAP_IMM_W (TRAP_IMM_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .kind_i   (kind),
        .pc_i     (pc_i),
        .opr_i    (opr_i),
        .imm_i    (disp_i[TRAP_IMM_W-1:0]),
        .pr_o     (pr_o),
        .ssr_o    (ssr),
        .spc_o    (spc),
        .tra_o    (tra_o)
    );

    dsb_slot_ctrl #(
        .PC_STEP  (PC_STEP),
        .RESET_PC (RESET_PC)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .retire_i   (retire_i),
        .kind_i     (kind),
        .pc_i       (pc_i),
        .dly_i      (redir.dly),
        .taken_i    (redir.taken),
        .target_i   (redir.target),
        .ssr_i      (ssr),
        .accept_o   (accept),
        .next_pc_o  (next_pc_o),
        .in_slot_o  (in_slot_o),
        .taken_o    (taken_o),
        .exc_req_o  (exc_req_o),
        .exc_code_o (exc_code_o),
        .sr_wr_o    (sr_wr_o),
        .sr_val_o   (sr_val_o)
    );

endmodule

// File: rtl/dsb_checker.sv
module dsb_checker
    import dsb_pkg::*;
#(
    parameter int PC_STEP = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  retire_i,
    input logic [3:0]            kind_i,
    input logic [DSB_XLEN-1:0]   pc_i,
    input logic [DSB_XLEN-1:0]   disp_i,
    input logic [DSB_XLEN-1:0]   next_pc_o,
    input logic                  in_slot_o,
    input logic                  taken_o,
    input logic [DSB_XLEN-1:0]   pr_o,
    input logic [DSB_XLEN-1:0]   tra_o,
    input logic                  exc_req_o,
    input logic [DSB_CODE_W-1:0] exc_code_o,
    input logic                  sr_wr_o
);

    kind_e k;
    assign k = kind_e'(kind_i);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!in_slot_o && !taken_o && !exc_req_o && !sr_wr_o));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (retire_i && !in_slot_o && k == K_NONE)
        |=> (next_pc_o == $past(pc_i) + DSB_XLEN'(PC_STEP)) && !exc_req_o);

    assert_slot_opens_R3: assert property (@(posedge clk) disable iff (rst)
        (retire_i && !in_slot_o && is_delayed(k)) |=> in_slot_o);

    assert_slot_closes_R7: assert property (@(posedge clk) disable iff (rst)
        (retire_i && in_slot_o) |=> !in_slot_o && !taken_o);

    assert_taken_needs_slot_R7: assert property (@(posedge clk) disable iff (rst)
        taken_o |-> in_slot_o);

    assert_trap_code_R8: assert property (@(posedge clk) disable iff (rst)
        (retire_i && !in_slot_o && k == K_TRAP)
        |=> exc_req_o && exc_code_o == EXC_TRAP
            && tra_o == (DSB_XLEN'($past(disp_i[7:0])) << 2));

    assert_undef_code_R9: assert property (@(posedge clk) disable iff (rst)
        (retire_i && !in_slot_o && k == K_UNDEF)
        |=> exc_req_o && exc_code_o == EXC_UNDEF);

    assert_slot_fault_R10: assert property (@(posedge clk) disable iff (rst)
        (retire_i && in_slot_o && faults_in_slot(k))
        |=> exc_req_o && exc_code_o == EXC_SLOT_FLT && $stable(pr_o));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !retire_i |=> $stable(next_pc_o) && $stable(in_slot_o)
                      && $stable(pr_o) && !exc_req_o && !sr_wr_o);

endmodule

bind dslot_branch_unit dsb_checker #(
    .PC_STEP (PC_STEP)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .retire_i   (retire_i),
    .kind_i     (kind_i),
    .pc_i       (pc_i),
    .disp_i     (disp_i),
    .next_pc_o  (next_pc_o),
    .in_slot_o  (in_slot_o),
    .taken_o    (taken_o),
    .pr_o       (pr_o),
    .tra_o      (tra_o),
    .exc_req_o  (exc_req_o),
    .exc_code_o (exc_code_o),
    .sr_wr_o    (sr_wr_o)
);

// File: tb/dslot_branch_unit_tb.sv
module dslot_branch_unit_tb;
    import dsb_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        retire_i = 1'b0;
    logic [3:0]  kind_i = 4'd0;
    logic [31:0] pc_i = '0, disp_i = '0, opr_i = '0;
    logic        t_i = 1'b0;
    logic [31:0] next_pc_o, pr_o, tra_o, sr_val_o;
    logic        in_slot_o, taken_o, exc_req_o, sr_wr_o;
    logic [11:0] exc_code_o;

    always #4 clk = ~clk;

    dslot_branch_unit u_dut (
        .clk(clk), .rst(rst), .retire_i(retire_i), .kind_i(kind_i),
        .pc_i(pc_i), .disp_i(disp_i), .opr_i(opr_i), .t_i(t_i),
        .next_pc_o(next_pc_o), .in_slot_o(in_slot_o), .taken_o(taken_o),
        .pr_o(pr_o), .tra_o(tra_o), .exc_req_o(exc_req_o),
        .exc_code_o(exc_code_o), .sr_wr_o(sr_wr_o), .sr_val_o(sr_val_o)
    );

    typedef struct packed {
        logic [3:0]  kind;
        logic [31:0] pc;
        logic [31:0] disp;
        logic [31:0] opr;
        logic        t;
        logic [31:0] npc;
        logic        slot;
        logic        taken;
        logic        exc;
        logic [11:0] code;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{K_NONE,  32'h100,  32'h0,  32'h0,    1'b0, 32'h102,  1'b0, 1'b0, 1'b0, 12'h0},   // R2
        '{K_BT,    32'h102,  32'h20, 32'h0,    1'b1, 32'h104,  1'b1, 1'b1, 1'b0, 12'h0},   // R3 taken
        '{K_NONE,  32'h104,  32'h0,  32'h0,    1'b0, 32'h126,  1'b0, 1'b0, 1'b0, 12'h0},   // R7
        '{K_BF,    32'h126,  32'h10, 32'h0,    1'b1, 32'h128,  1'b1, 1'b0, 1'b0, 12'h0},   // R3 not taken
        '{K_NONE,  32'h128,  32'h0,  32'h0,    1'b0, 32'h12A,  1'b0, 1'b0, 1'b0, 12'h0},   // R7
        '{K_BF,    32'h12A,  32'h40, 32'h0,    1'b0, 32'h12C,  1'b1, 1'b1, 1'b0, 12'h0},   // R3
        '{K_NONE,  32'h12C,  32'h0,  32'h0,    1'b0, 32'h16E,  1'b0, 1'b0, 1'b0, 12'h0},   // R7
        '{K_BRAR,  32'h16E,  32'h0,  32'h100,  1'b0, 32'h170,  1'b1, 1'b1, 1'b0, 12'h0},   // R4
        '{K_NONE,  32'h170,  32'h0,  32'h0,    1'b0, 32'h272,  1'b0, 1'b0, 1'b0, 12'h0},   // R4
        '{K_JCALL, 32'h272,  32'h0,  32'h8000, 1'b0, 32'h274,  1'b1, 1'b1, 1'b0, 12'h0},   // R5
        '{K_NONE,  32'h274,  32'h0,  32'h0,    1'b0, 32'h8000, 1'b0, 1'b0, 1'b0, 12'h0},   // R4
        '{K_RET,   32'h8000, 32'h0,  32'h0,    1'b0, 32'h8002, 1'b1, 1'b1, 1'b0, 12'h0},   // R5
        '{K_NONE,  32'h8002, 32'h0,  32'h0,    1'b0, 32'h276,  1'b0, 1'b0, 1'b0, 12'h0},   // R5
        '{K_BRA,   32'h276,  32'hFFFFFFF8, 32'h0, 1'b0, 32'h278, 1'b1, 1'b1, 1'b0, 12'h0}, // R4
        '{K_BT,    32'h278,  32'h0,  32'h0,    1'b1, 32'h27A,  1'b0, 1'b0, 1'b1, 12'h1A0}, // R10
        '{K_NONE,  32'h27A,  32'h0,  32'h0,    1'b0, 32'h27C,  1'b0, 1'b0, 1'b0, 12'h0},   // R10 dropped
        '{K_UNDEF, 32'h27C,  32'h0,  32'h0,    1'b0, 32'h27E,  1'b0, 1'b0, 1'b1, 12'h180}, // R9
        '{K_TRAP,  32'h27E,  32'h12, 32'h0,    1'b0, 32'h280,  1'b0, 1'b0, 1'b1, 12'h160}, // R8
        '{K_CALL,  32'h280,  32'h100,32'h0,    1'b0, 32'h282,  1'b1, 1'b1, 1'b0, 12'h0},   // R4
        '{K_UNDEF, 32'h282,  32'h0,  32'h0,    1'b0, 32'h284,  1'b0, 1'b0, 1'b1, 12'h1A0}, // R10
        '{K_LDSPC, 32'h284,  32'h0,  32'h4000, 1'b0, 32'h286,  1'b0, 1'b0, 1'b0, 12'h0},   // R12
        '{K_LDSSR, 32'h286,  32'h0,  32'h700000F0, 1'b0, 32'h288, 1'b0, 1'b0, 1'b0, 12'h0}, // R12
        '{K_ERET,  32'h288,  32'h0,  32'h0,    1'b0, 32'h28A,  1'b1, 1'b1, 1'b0, 12'h0},   // R6
        '{K_NONE,  32'h28A,  32'h0,  32'h0,    1'b0, 32'h4000, 1'b0, 1'b0, 1'b0, 12'h0},   // R6
        '{K_CALLR, 32'h4000, 32'h0,  32'h10,   1'b0, 32'h4002, 1'b1, 1'b1, 1'b0, 12'h0},   // R4
        '{K_LDPR,  32'h4002, 32'h0,  32'h9999, 1'b0, 32'h4014, 1'b0, 1'b0, 1'b0, 12'h0},   // R12 in slot
        '{K_JMP,   32'h4014, 32'h0,  32'h5000, 1'b0, 32'h4016, 1'b1, 1'b1, 1'b0, 12'h0},   // R4
        '{K_JMP,   32'h4016, 32'h0,  32'h6000, 1'b0, 32'h4018, 1'b0, 1'b0, 1'b1, 12'h1A0}, // R10
        '{K_RET,   32'h4018, 32'h0,  32'h0,    1'b0, 32'h401A, 1'b1, 1'b1, 1'b0, 12'h0},   // R12
        '{K_NONE,  32'h401A, 32'h0,  32'h0,    1'b0, 32'h9999, 1'b0, 1'b0, 1'b0, 12'h0}    // R12
    };

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] k, input logic [31:0] pc, input logic [31:0] d,
                        input logic [31:0] r, input logic t, input logic ret);
        @(negedge clk);
        kind_i = k; pc_i = pc; disp_i = d; opr_i = r; t_i = t; retire_i = ret;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1 next_pc", 64'(next_pc_o), 64'h A000_0000);
        chk("R1 flags", 64'({in_slot_o, taken_o, exc_req_o, sr_wr_o}), 64'h0);
        chk("R1 regs", 64'({pr_o, tra_o}), 64'h0);
        chk("R1 code", 64'(exc_code_o), 64'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].kind, VECS[i].pc, VECS[i].disp, VECS[i].opr, VECS[i].t, 1'b1);
            chk($sformatf("R2-table vector %0d (R3 R4 R5 R6 R7 R8 R9 R10 R12)", i),
                64'({next_pc_o, in_slot_o, taken_o, exc_req_o, exc_code_o}),
                64'({VECS[i].npc, VECS[i].slot, VECS[i].taken, VECS[i].exc, VECS[i].code}));
        end

        // R8 trap register value and one-cycle pulse
        step(K_TRAP, 32'h500, 32'hFF, 32'h0, 1'b0, 1'b1);
        chk("R8 tra", 64'(tra_o), 64'h3FC);
        chk("R8 code", 64'({exc_req_o, exc_code_o}), 64'({1'b1, 12'h160}));
        step(K_NONE, 32'h502, 32'h0, 32'h0, 1'b0, 1'b0);
        chk("R8 pulse ends", 64'(exc_req_o), 64'h0);

        // R6 status restore strobe
        step(K_LDSSR, 32'h502, 32'h0, 32'h1234, 1'b0, 1'b1);
        step(K_LDSPC, 32'h504, 32'h0, 32'h600, 1'b0, 1'b1);
        step(K_ERET, 32'h510, 32'h0, 32'h0, 1'b0, 1'b1);
        chk("R6 sr strobe", 64'({sr_wr_o, sr_val_o}), 64'({1'b1, 32'h1234}));

        // R11 retire gaps while a taken branch is pending, undefined kind on the bus
        for (int j = 0; j < 3; j++) begin
            step(K_UNDEF, 32'h512, 32'h0, 32'h0, 1'b0, 1'b0);
            chk("R11 hold", 64'({next_pc_o, in_slot_o, taken_o, exc_req_o, sr_wr_o}),
                64'({32'h512, 1'b1, 1'b1, 1'b0, 1'b0}));
        end
        step(K_NONE, 32'h512, 32'h0, 32'h0, 1'b0, 1'b1);
        chk("R6 saved pc target", 64'(next_pc_o), 64'h600);

        // R5 return address of a call
        step(K_CALL, 32'h600, 32'h0, 32'h0, 1'b0, 1'b1);
        chk("R5 pr", 64'(pr_o), 64'h604);
        step(K_NONE, 32'h602, 32'h0, 32'h0, 1'b0, 1'b1);
        chk("R7 call target", 64'(next_pc_o), 64'h604);

        // R10 call inside a slot must not write the return register
        step(K_BRA, 32'h604, 32'h10, 32'h0, 1'b0, 1'b1);
        step(K_JCALL, 32'h606, 32'h0, 32'h7777, 1'b0, 1'b1);
        chk("R10 pr unchanged", 64'(pr_o), 64'h604);
        chk("R10 fault", 64'({next_pc_o, exc_req_o, exc_code_o}),
            64'({32'h608, 1'b1, 12'h1A0}));

        // R1 reset from a pending state
        step(K_BT, 32'h700, 32'h0, 32'h0, 1'b1, 1'b1);
        @(negedge clk);
        rst = 1'b1; retire_i = 1'b0;
        @(posedge clk);
        #2;
        chk("R1 re-reset", 64'({next_pc_o, in_slot_o, taken_o, pr_o}),
            64'({32'hA000_0000, 1'b0, 1'b0, 32'h0}));
        @(negedge clk);
        rst = 1'b0;

        finish_run();
    end

endmodule